// File: doc/BRIEF.md
# Address-Verified Nibble-Pair Output Latch

This block sits behind a serial frame receiver. Each decoded frame carries a 3-bit address, a 4-bit data nibble and the receiver's measured bit period in clock cycles. The block pairs two consecutive frames into one byte: the first supplies the low nibble and the second the high nibble. The pair is kept only when the two addresses agree with each other and with the local 3-bit strap address. Up to eight such blocks can therefore listen to one shared serial line.

A frame is presented as a one-cycle `frm_valid` pulse. The receiver raises it at the start of the frame's last data bit, with `frm_addr`, `frm_nib` and `frm_bitlen` valid in that cycle. When a good pair completes, the byte register loads half a bit period later. At the same moment an active-low acknowledge pulse begins and lasts one bit period. Both durations come from the count that arrives with the second frame.

The output stage is modelled by two 8-bit vectors. `pin_val` holds the level each pin would drive, and `pin_en` shows whether that pin is actively driven. In open-drain mode a stored 1 pulls the pin low and a stored 0 releases it. In push-pull mode the pins carry the stored data, and they float as a group when the output enable is low.

Top module: `nibble_pair_latch`

## Requirements
- R1: The first accepted frame's nibble becomes byte bits 3:0 and the second frame's nibble becomes bits 7:4.
- R2: If a pair is open and a frame arrives whose address differs from the held first frame's address, the pair is abandoned. The byte register and `ack_n` are left untouched.
- R3: When no pair is open, a frame whose address differs from `strap_addr` is ignored and does not open a pair.
- R4: After a good pair, `ack_n` is low for exactly `frm_bitlen` cycles, taken from the second frame (a count of 0 acts as 1), starting on the clock edge that loads the byte. Otherwise `ack_n` is high.
- R5: The byte register loads on the clock edge that lies H edges after the edge sampling the second frame's `frm_valid`. H is `frm_bitlen` divided by two and rounded down, with a minimum of 1.
- R6: In open-drain mode (`od_mode`=1), `pin_val` is all zeros and `pin_en` equals the stored byte: a stored 1 drives low, a stored 0 releases. `out_en` has no effect in this mode.
- R7: In push-pull mode (`od_mode`=0), `pin_val` equals the stored byte. `pin_en` is all ones when `out_en`=1 and all zeros (high impedance) when `out_en`=0.
- R8: Asynchronous active-low `rst_n` clears the byte register to 0x00, closes any open pair, cancels any pending load and sets `ack_n` high.
- R9: After a pair is abandoned, or after a reset, the next frame that matches the straps is taken as a new low-nibble frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 3 | Local device address |
| frm_valid | input | 1 | One-cycle pulse marking a decoded frame |
| frm_addr | input | 3 | Address field of the frame |
| frm_nib | input | 4 | Data nibble of the frame |
| frm_bitlen | input | CW | Measured bit period of the frame in clock cycles |
| od_mode | input | 1 | 1 = open-drain output stage, 0 = push-pull |
| out_en | input | 1 | Push-pull output enable, active high |
| pin_val | output | 8 | Level driven on each output pin |
| pin_en | output | 8 | Per-pin drive enable (0 = released / high impedance) |
| ack_n | output | 1 | Active-low acknowledge pulse |

## Verification
The hardest case to reach is a first frame that matched the straps, followed by a second frame carrying another device's address. The stimulus has to open a pair and then break it, and the state left behind can only be seen through the next pair that completes. The vector table therefore places a broken pair right before a good pair and checks that the good byte assembles from the frames that follow the break. A directed test resets the block while a pair is open, then checks that the next two matching frames form a fresh byte in low-then-high order.

// File: rtl/nibble_pair_latch.sv
module nibble_pair_latch #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    strap_addr,
  input  logic          frm_valid,
  input  logic [2:0]    frm_addr,
  input  logic [3:0]    frm_nib,
  input  logic [CW-1:0] frm_bitlen,
  input  logic          od_mode,
  input  logic          out_en,
  output logic [7:0]    pin_val,
  output logic [7:0]    pin_en,
  output logic          ack_n
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          open_q;
  logic [2:0]    lo_addr_q;
  logic [3:0]    lo_nib_q;
  logic          pend_q;
  logic [7:0]    hold_q;
  logic [CW-1:0] wait_q;
  logic [CW-1:0] alen_q;
  logic [CW-1:0] ack_q;
  logic [7:0]    data_q;

  logic          hit;
  logic          pair_ok;
  logic [CW-1:0] half;
  logic [CW-1:0] alen;

  assign hit     = frm_valid && (frm_addr == strap_addr);
  assign pair_ok = frm_valid && open_q && (frm_addr == lo_addr_q);
  assign half    = ((frm_bitlen >> 1) == '0) ? ONE : (frm_bitlen >> 1);
  assign alen    = (frm_bitlen == '0) ? ONE : frm_bitlen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      lo_addr_q <= '0;
      lo_nib_q  <= '0;
    end else if (frm_valid) begin
      if (!open_q) begin
        if (hit) begin
          open_q    <= 1'b1;
          lo_addr_q <= frm_addr;
          lo_nib_q  <= frm_nib;
        end
      end else begin
        open_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= '0;
      wait_q <= '0;
      alen_q <= '0;
      ack_q  <= '0;
      data_q <= '0;
    end else begin
      if (pend_q) begin
        if (wait_q == ONE) begin
          data_q <= hold_q;
          ack_q  <= alen_q;
          pend_q <= 1'b0;
        end else begin
          wait_q <= wait_q - ONE;
          if (ack_q != '0) ack_q <= ack_q - ONE;
        end
      end else if (ack_q != '0) begin
        ack_q <= ack_q - ONE;
      end
      if (pair_ok) begin
        pend_q <= 1'b1;
        hold_q <= {frm_nib, lo_nib_q};
        wait_q <= half;
        alen_q <= alen;
      end
    end
  end

  assign ack_n   = (ack_q == '0);
  assign pin_val = od_mode ? 8'h00 : data_q;
  assign pin_en  = od_mode ? data_q : {8{out_en}};

  p_drop_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && open_q && frm_addr != lo_addr_q && !pend_q) |=> (!pend_q && !open_q));

  p_foreign_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !open_q && frm_addr != strap_addr) |=> !open_q);

  p_ack_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && wait_q == ONE) |=> !ack_n);

  p_ack_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_n && !pend_q) |=> ack_n);

  p_load_only_when_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && wait_q == ONE) |=> $stable(data_q));

  p_open_needs_strap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> (lo_addr_q == $past(strap_addr)));

endmodule

// File: tb/tb_nibble_pair_latch.sv
module tb_nibble_pair_latch;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    strap_addr = 3'd5;
  logic          frm_valid = 1'b0;
  logic [2:0]    frm_addr = '0;
  logic [3:0]    frm_nib = '0;
  logic [CW-1:0] frm_bitlen = '0;
  logic          od_mode = 1'b0;
  logic          out_en = 1'b1;
  logic [7:0]    pin_val, pin_en;
  logic          ack_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] cur = 8'h00;

  always #4 clk = ~clk;

  nibble_pair_latch #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .frm_valid(frm_valid),
    .frm_addr(frm_addr), .frm_nib(frm_nib), .frm_bitlen(frm_bitlen),
    .od_mode(od_mode), .out_en(out_en), .pin_val(pin_val), .pin_en(pin_en), .ack_n(ack_n)
  );

  // {lo_addr, lo_nib, hi_addr, hi_nib, update, expected byte, bit length}
  localparam logic [30:0] VEC [7] = '{
    {3'd5, 4'hA, 3'd5, 4'h3, 1'b1, 8'h3A, 8'd6},
    {3'd5, 4'hF, 3'd2, 4'h0, 1'b0, 8'h3A, 8'd6},
    {3'd5, 4'h4, 3'd5, 4'h7, 1'b1, 8'h74, 8'd9},
    {3'd5, 4'h0, 3'd5, 4'h0, 1'b1, 8'h00, 8'd3},
    {3'd5, 4'h5, 3'd4, 4'h5, 1'b0, 8'h00, 8'd8},
    {3'd5, 4'hF, 3'd5, 4'hF, 1'b1, 8'hFF, 8'd4},
    {3'd5, 4'h6, 3'd5, 4'h9, 1'b1, 8'h96, 8'd10}
  };

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [2:0] a, input logic [3:0] n, input logic [7:0] bl);
    @(negedge clk);
    frm_valid = 1'b1; frm_addr = a; frm_nib = n; frm_bitlen = bl;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic expect_load(input logic [7:0] exp, input logic [7:0] bl, input string req);
    int h;
    h = (bl >> 1) == 0 ? 1 : int'(bl >> 1);
    repeat (h - 1) @(negedge clk);
    chk(pin_val == cur && ack_n, {req, " R5 before load"}, {pin_val, 7'd0, ack_n}, {cur, 8'h01});
    @(negedge clk);
    chk(pin_val == exp && !ack_n, {req, " R5 load and R4 ack start"}, {pin_val, 7'd0, ack_n}, {exp, 8'h00});
    cur = exp;
    repeat (int'(bl) - 1) @(negedge clk);
    chk(!ack_n, "R4 ack still low at end of period", {15'd0, ack_n}, 16'h0000);
    @(negedge clk);
    chk(ack_n, "R4 ack released after one period", {15'd0, ack_n}, 16'h0001);
  endtask

  task automatic expect_none(input logic [7:0] bl, input string req);
    logic bad;
    bad = 1'b0;
    repeat (int'(bl) + 4) begin
      @(negedge clk);
      if (pin_val != cur || !ack_n) bad = 1'b1;
    end
    chk(!bad, {req, " no load, no ack"}, {pin_val, 7'd0, ack_n}, {cur, 8'h01});
  endtask

  initial begin
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pin_val == 8'h00 && pin_en == 8'hFF && ack_n, "R8 reset state",
        {pin_val, 7'd0, ack_n}, 16'h0001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      frame(VEC[i][30:28], VEC[i][27:24], VEC[i][7:0]);
      repeat (2) @(negedge clk);
      frame(VEC[i][23:21], VEC[i][20:17], VEC[i][7:0]);
      if (VEC[i][16]) expect_load(VEC[i][15:8], VEC[i][7:0], (i == 2) ? "R9 R1" : "R1");
      else expect_none(VEC[i][7:0], "R2");
      repeat (3) @(negedge clk);
    end

    // R3: foreign frame while idle opens nothing
    frame(3'd3, 4'h9, 8'd6);
    expect_none(8'd6, "R3");
    frame(3'd5, 4'h2, 8'd6);
    frame(3'd5, 4'hC, 8'd6);
    expect_load(8'hC2, 8'd6, "R3 R1");

    // R6: open-drain encoding, out_en ignored
    @(negedge clk); od_mode = 1'b1;
    #1 chk(pin_val == 8'h00 && pin_en == 8'hC2, "R6 open-drain", {pin_val, pin_en}, {8'h00, 8'hC2});
    @(negedge clk); out_en = 1'b0;
    #1 chk(pin_en == 8'hC2, "R6 enable ignored", {8'h00, pin_en}, {8'h00, 8'hC2});

    // R7: push-pull enable
    @(negedge clk); od_mode = 1'b0;
    #1 chk(pin_en == 8'h00 && pin_val == 8'hC2, "R7 high impedance", {pin_val, pin_en}, {8'hC2, 8'h00});
    @(negedge clk); out_en = 1'b1;
    #1 chk(pin_en == 8'hFF && pin_val == 8'hC2, "R7 driven", {pin_val, pin_en}, {8'hC2, 8'hFF});

    // R8 / R9: reset with a pair open, then a fresh pair
    frame(3'd5, 4'hA, 8'd6);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(pin_val == 8'h00 && ack_n, "R8 mid-run reset", {pin_val, 7'd0, ack_n}, 16'h0001);
    cur = 8'h00;
    rst_n = 1'b1;
    frame(3'd5, 4'h7, 8'd5);
    frame(3'd5, 4'h1, 8'd5);
    expect_load(8'h17, 8'd5, "R9 after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule